// File: doc/BRIEF.md
# Fused Memory-Modify and Accumulator Execute Unit

This block is the execute stage for the opcodes of an 8-bit accumulator CPU whose two low bits are both set. Each such opcode pairs a memory modification (shift, rotate, increment, decrement or an A-and-X store) with an accumulator operation from the same opcode row. The sequencer presents the opcode, the operand byte fetched from memory, the current A and X registers and the carry flag, and pulses `op_valid`. One cycle later the unit returns the modified byte with a write strobe, together with the addressing-mode code the sequencer needs. One further cycle later, in the slot where the next opcode is fetched, it presents the new A and X values and the N, Z, C and V flags with one write enable each.

The immediate column (opcode bits 4:2 = 010) has no memory phase: no write strobe is raised, and its whole result arrives in the same commit slot as every other form. Opcodes with unstable behaviour, and opcodes whose low bits are not 11, are rejected with an `unsupported` pulse and change no state. The register file and the flag register sit outside the block and take the commit outputs.

Top module: `fused_rmw_alu_unit`

## Requirements
- R1: An opcode whose bits 1:0 are not 11, or one of 0x8B, 0x93, 0x9B, 0x9F, 0xBB, raises `unsupported` in the cycle after `op_valid` and produces neither `mem_we` nor `commit`.
- R2: For a supported non-immediate opcode other than row 101 (bits 7:5), `mem_we` and `mem_wdata` appear in the cycle after `op_valid`. Row 000 shifts left with 0 entering; 001 rotates left through carry; 010 shifts right with 0 entering; 011 rotates right through carry; 110 decrements; 111 increments.
- R3: `commit` pulses exactly two cycles after `op_valid` for every supported opcode, which is exactly one cycle after `mem_we` for forms that write; `mem_we` is low in the commit cycle.
- R4: Rows 000, 001 and 010 (memory forms) OR, AND and XOR the modified byte into A; C is the bit shifted out; N and Z follow the new A. Flag mask bits are [3]=N, [2]=Z, [1]=C, [0]=V.
- R5: Row 011 (memory form) adds the rotated byte to A with the rotate's carry-out as carry-in and writes N, Z, C and V.
- R6: Row 110 (memory form) compares A with the decremented byte: C is set when A is at least that byte, N and Z come from the difference, and A is not written.
- R7: Row 111 subtracts the incremented byte from A with borrow equal to the inverted input carry and writes N, Z, C and V.
- R8: Row 100 writes A AND X to memory and, at commit, writes neither A, X nor any flag.
- R9: Row 101 loads the operand into both A and X, sets N and Z from it, and never raises `mem_we`.
- R10: Immediate forms never raise `mem_we`. 0x0B and 0x2B set A to A AND operand with C equal to its bit 7; 0x4B shifts (A AND operand) right with C from bit 0; 0x6B rotates (A AND operand) right through carry with C = result bit 6 and V = bit 6 XOR bit 5; 0xCB sets X to (A AND X) minus operand with C meaning no borrow; 0xEB subtracts with borrow exactly like row 111.
- R11: `mode_code` equals opcode bits 4:2 in the cycle after `op_valid`.
- R12: While and after reset, `mem_we`, `commit`, `unsupported` and all write enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Opcode and operand are present this cycle |
| opcode | input | 8 | Opcode byte |
| operand | input | DW | Fetched memory byte or immediate value |
| acc_in | input | DW | Current A |
| idx_in | input | DW | Current X |
| carry_in | input | 1 | Current carry flag |
| mem_wdata | output | DW | Modified byte to store |
| mem_we | output | 1 | Store strobe |
| mode_code | output | 3 | Addressing-mode code for the sequencer |
| unsupported | output | 1 | Opcode rejected |
| commit | output | 1 | Register and flag results valid |
| acc_out | output | DW | New A |
| acc_we | output | 1 | Write enable for A |
| idx_out | output | DW | New X |
| idx_we | output | 1 | Write enable for X |
| flags_out | output | 4 | New N, Z, C, V |
| flags_we | output | 4 | Per-flag write enables |

## Verification
The hardest situation to reach is the hand-off between the two slots: the carry that the memory stage shifts out must arrive as the carry-in of the accumulator stage a cycle later, and it must not be confused with the input carry. Rotate-then-add and shift-then-logic vectors are chosen so that the shifted-out bit differs from `carry_in`, and the bench samples the write slot and the commit slot separately, so a result that lands one cycle early or late, or with the wrong carry, shows at the ports. A few hundred random opcodes and operands, compared with a model written from the requirements, cover the remaining combinations, including rejected opcodes.

// File: rtl/fused_pkg.sv
package fused_pkg;
  localparam int OP_W = 8;
  localparam int MODE_W = 3;
  localparam int FLAG_W = 4;
  localparam int FLG_N = 3;
  localparam int FLG_Z = 2;
  localparam int FLG_C = 1;
  localparam int FLG_V = 0;
  localparam logic [MODE_W-1:0] MODE_IMM = 3'b010;

  typedef enum logic [2:0] {
    ROW_ASL_OR   = 3'd0,
    ROW_ROL_AND  = 3'd1,
    ROW_LSR_XOR  = 3'd2,
    ROW_ROR_ADD  = 3'd3,
    ROW_STORE_AX = 3'd4,
    ROW_LOAD_AX  = 3'd5,
    ROW_DEC_CMP  = 3'd6,
    ROW_INC_SUB  = 3'd7
  } row_e;
endpackage

// File: rtl/fx_decode.sv
module fx_decode
  import fused_pkg::*;
(
  input  logic [OP_W-1:0]   opcode,
  output row_e              row,
  output logic [MODE_W-1:0] mode,
  output logic              imm,
  output logic              ok,
  output logic              writes_mem
);
  logic unstable;

  always_comb begin
    unique case (opcode)
      8'h8B, 8'h93, 8'h9B, 8'h9F, 8'hBB: unstable = 1'b1;
      default:                           unstable = 1'b0;
    endcase
  end

  assign row        = row_e'(opcode[7:5]);
  assign mode       = opcode[4:2];
  assign imm        = (opcode[4:2] == MODE_IMM);
  assign ok         = (opcode[1:0] == 2'b11) && !unstable;
  assign writes_mem = ok && !imm && (row != ROW_LOAD_AX);
endmodule

// File: rtl/fx_rmw.sv
module fx_rmw
  import fused_pkg::*;
#(
  parameter int DW = 8
) (
  input  row_e          row,
  input  logic [DW-1:0] mem_val,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] x,
  input  logic          cin,
  output logic [DW-1:0] mod_val,
  output logic          cout
);
  localparam logic [DW-1:0] ONE = DW'(1);

  always_comb begin
    mod_val = mem_val;
    cout    = cin;
    unique case (row)
      ROW_ASL_OR:   begin mod_val = {mem_val[DW-2:0], 1'b0}; cout = mem_val[DW-1]; end
      ROW_ROL_AND:  begin mod_val = {mem_val[DW-2:0], cin};  cout = mem_val[DW-1]; end
      ROW_LSR_XOR:  begin mod_val = {1'b0, mem_val[DW-1:1]}; cout = mem_val[0];    end
      ROW_ROR_ADD:  begin mod_val = {cin, mem_val[DW-1:1]};  cout = mem_val[0];    end
      ROW_STORE_AX: mod_val = a & x;
      ROW_LOAD_AX:  mod_val = mem_val;
      ROW_DEC_CMP:  mod_val = mem_val - ONE;
      ROW_INC_SUB:  mod_val = mem_val + ONE;
      default:      mod_val = mem_val;
    endcase
  end
endmodule

// File: rtl/fx_alu.sv
module fx_alu
  import fused_pkg::*;
#(
  parameter int DW = 8
) (
  input  row_e              row,
  input  logic              imm,
  input  logic [DW-1:0]     m,
  input  logic [DW-1:0]     a,
  input  logic [DW-1:0]     x,
  input  logic              cin,
  output logic [DW-1:0]     a_new,
  output logic              a_we,
  output logic [DW-1:0]     x_new,
  output logic              x_we,
  output logic [FLAG_W-1:0] fl,
  output logic [FLAG_W-1:0] fl_we
);
  localparam int MSB = DW - 1;

  logic [DW-1:0] lhs, res, t;
  logic [DW:0]   sum_add, sum_sub;
  logic          sub_cin;

  assign lhs     = (row == ROW_DEC_CMP && imm) ? (a & x) : a;
  assign sub_cin = (row == ROW_DEC_CMP) ? 1'b1 : cin;
  assign sum_add = {1'b0, a} + {1'b0, m} + {{DW{1'b0}}, cin};
  assign sum_sub = {1'b0, lhs} + {1'b0, ~m} + {{DW{1'b0}}, sub_cin};
  assign t       = a & m;

  always_comb begin
    a_new = a;
    x_new = x;
    a_we  = 1'b0;
    x_we  = 1'b0;
    fl    = '0;
    fl_we = '0;
    res   = a;
    unique case (row)
      ROW_ASL_OR, ROW_ROL_AND: begin
        if (imm) begin
          res = t;
          fl[FLG_C] = t[MSB];
        end else begin
          res = (row == ROW_ASL_OR) ? (a | m) : (a & m);
          fl[FLG_C] = cin;
        end
        fl_we = 4'b1110;
      end
      ROW_LSR_XOR: begin
        if (imm) begin
          res = {1'b0, t[MSB:1]};
          fl[FLG_C] = t[0];
        end else begin
          res = a ^ m;
          fl[FLG_C] = cin;
        end
        fl_we = 4'b1110;
      end
      ROW_ROR_ADD: begin
        if (imm) begin
          res = {cin, t[MSB:1]};
          fl[FLG_C] = res[MSB-1];
          fl[FLG_V] = res[MSB-1] ^ res[MSB-2];
        end else begin
          res = sum_add[DW-1:0];
          fl[FLG_C] = sum_add[DW];
          fl[FLG_V] = (a[MSB] == m[MSB]) && (res[MSB] != a[MSB]);
        end
        fl_we = 4'b1111;
      end
      ROW_LOAD_AX: begin
        res   = m;
        x_new = m;
        x_we  = 1'b1;
        fl_we = 4'b1100;
      end
      ROW_DEC_CMP: begin
        res = sum_sub[DW-1:0];
        fl[FLG_C] = sum_sub[DW];
        fl_we = 4'b1110;
        if (imm) begin
          x_new = res;
          x_we  = 1'b1;
        end
      end
      ROW_INC_SUB: begin
        res = sum_sub[DW-1:0];
        fl[FLG_C] = sum_sub[DW];
        fl[FLG_V] = (a[MSB] != m[MSB]) && (res[MSB] != a[MSB]);
        fl_we = 4'b1111;
      end
      default: fl_we = '0;
    endcase
    fl[FLG_N] = res[MSB];
    fl[FLG_Z] = (res == '0);
    if (row != ROW_STORE_AX && row != ROW_DEC_CMP) begin
      a_new = res;
      a_we  = 1'b1;
    end
  end
endmodule

// File: rtl/fused_rmw_alu_unit.sv
module fused_rmw_alu_unit
  import fused_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  input  logic [OP_W-1:0]   opcode,
  input  logic [DW-1:0]     operand,
  input  logic [DW-1:0]     acc_in,
  input  logic [DW-1:0]     idx_in,
  input  logic              carry_in,
  output logic [DW-1:0]     mem_wdata,
  output logic              mem_we,
  output logic [MODE_W-1:0] mode_code,
  output logic              unsupported,
  output logic              commit,
  output logic [DW-1:0]     acc_out,
  output logic              acc_we,
  output logic [DW-1:0]     idx_out,
  output logic              idx_we,
  output logic [FLAG_W-1:0] flags_out,
  output logic [FLAG_W-1:0] flags_we
);
  row_e              d_row;
  logic [MODE_W-1:0] d_mode;
  logic              d_imm, d_ok, d_wr;
  logic [DW-1:0]     r_mod;
  logic              r_cout;

  row_e              s1_row;
  logic              s1_live, s1_imm, s1_c;
  logic [DW-1:0]     s1_m, s1_a, s1_x;

  logic [DW-1:0]     x_acc, x_idx;
  logic              x_awe, x_xwe;
  logic [FLAG_W-1:0] x_fl, x_flwe;

  fx_decode u_dec (
    .opcode(opcode), .row(d_row), .mode(d_mode),
    .imm(d_imm), .ok(d_ok), .writes_mem(d_wr)
  );

  fx_rmw #(.DW(DW)) u_rmw (
    .row(d_row), .mem_val(operand), .a(acc_in), .x(idx_in),
    .cin(carry_in), .mod_val(r_mod), .cout(r_cout)
  );

  // Slot 1: memory result and captured state for the deferred stage.
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_live     <= 1'b0;
      mem_we      <= 1'b0;
      unsupported <= 1'b0;
      mem_wdata   <= '0;
      mode_code   <= '0;
      s1_row      <= ROW_ASL_OR;
      s1_imm      <= 1'b0;
      s1_m        <= '0;
      s1_a        <= '0;
      s1_x        <= '0;
      s1_c        <= 1'b0;
    end else begin
      s1_live     <= op_valid && d_ok;
      mem_we      <= op_valid && d_wr;
      unsupported <= op_valid && !d_ok;
      if (op_valid) begin
        mem_wdata <= r_mod;
        mode_code <= d_mode;
        s1_row    <= d_row;
        s1_imm    <= d_imm;
        s1_m      <= d_imm ? operand : r_mod;
        s1_c      <= d_imm ? carry_in : r_cout;
        s1_a      <= acc_in;
        s1_x      <= idx_in;
      end
    end
  end

  fx_alu #(.DW(DW)) u_alu (
    .row(s1_row), .imm(s1_imm), .m(s1_m), .a(s1_a), .x(s1_x), .cin(s1_c),
    .a_new(x_acc), .a_we(x_awe), .x_new(x_idx), .x_we(x_xwe),
    .fl(x_fl), .fl_we(x_flwe)
  );

  // Slot 2: accumulator, index and flag commit during the next fetch.
  always_ff @(posedge clk) begin
    if (rst) begin
      commit    <= 1'b0;
      acc_we    <= 1'b0;
      idx_we    <= 1'b0;
      flags_we  <= '0;
      acc_out   <= '0;
      idx_out   <= '0;
      flags_out <= '0;
    end else begin
      commit   <= s1_live;
      acc_we   <= s1_live && x_awe;
      idx_we   <= s1_live && x_xwe;
      flags_we <= s1_live ? x_flwe : '0;
      if (s1_live) begin
        acc_out   <= x_acc;
        idx_out   <= x_idx;
        flags_out <= x_fl & x_flwe;
      end
    end
  end

  // R3
  write_then_commit_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> (commit && !mem_we));

  // R10
  imm_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (mode_code != MODE_IMM));

  // R1
  reject_no_commit_chk: assert property (@(posedge clk) disable iff (rst)
    unsupported |=> !commit);

  // R9
  index_load_no_store_chk: assert property (@(posedge clk) disable iff (rst)
    (commit && idx_we) |-> !$past(mem_we));

  // R12
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!mem_we && !commit && !unsupported && !acc_we && !idx_we));
endmodule

// File: tb/fused_rmw_alu_unit_bench.sv
module fused_rmw_alu_unit_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       op_valid = 1'b0;
  logic [7:0] opcode = '0, operand = '0, acc_in = '0, idx_in = '0;
  logic       carry_in = 1'b0;
  logic [7:0] mem_wdata, acc_out, idx_out;
  logic       mem_we, unsupported, commit, acc_we, idx_we;
  logic [2:0] mode_code;
  logic [3:0] flags_out, flags_we;

  int nchk = 0;
  int nfail = 0;

  always #2 clk = ~clk;

  fused_rmw_alu_unit u_fused_rmw_alu_unit (
    .clk(clk), .rst(rst), .op_valid(op_valid), .opcode(opcode), .operand(operand),
    .acc_in(acc_in), .idx_in(idx_in), .carry_in(carry_in),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .mode_code(mode_code),
    .unsupported(unsupported), .commit(commit), .acc_out(acc_out), .acc_we(acc_we),
    .idx_out(idx_out), .idx_we(idx_we), .flags_out(flags_out), .flags_we(flags_we)
  );

  // {opcode, operand, A, X, carry, exp_mem, exp_A, exp_X, exp_NZCV}
  localparam logic [60:0] TAB [14] = '{
    {8'h07, 8'h81, 8'h10, 8'h00, 1'b0, 8'h02, 8'h12, 8'h00, 4'h2},
    {8'h27, 8'h40, 8'hFF, 8'h00, 1'b1, 8'h81, 8'h81, 8'h00, 4'h8},
    {8'h47, 8'h01, 8'h02, 8'h00, 1'b0, 8'h00, 8'h02, 8'h00, 4'h2},
    {8'h67, 8'h03, 8'h7F, 8'h00, 1'b0, 8'h01, 8'h81, 8'h00, 4'h9},
    {8'hC7, 8'h01, 8'h00, 8'h00, 1'b0, 8'h00, 8'h00, 8'h00, 4'h6},
    {8'hE7, 8'hFF, 8'h05, 8'h00, 1'b1, 8'h00, 8'h05, 8'h00, 4'h2},
    {8'h87, 8'h00, 8'hF0, 8'h3C, 1'b0, 8'h30, 8'h00, 8'h00, 4'h0},
    {8'hA7, 8'h80, 8'h00, 8'h00, 1'b0, 8'h00, 8'h80, 8'h80, 4'h8},
    {8'h0B, 8'hF0, 8'h8F, 8'h00, 1'b0, 8'h00, 8'h80, 8'h00, 4'hA},
    {8'h4B, 8'h03, 8'hFF, 8'h00, 1'b0, 8'h00, 8'h01, 8'h00, 4'h2},
    {8'h6B, 8'hC0, 8'hFF, 8'h00, 1'b1, 8'h00, 8'hE0, 8'h00, 4'hA},
    {8'hCB, 8'h0C, 8'h0F, 8'hFC, 1'b0, 8'h00, 8'h00, 8'h00, 4'h6},
    {8'hEB, 8'h01, 8'h80, 8'h00, 1'b1, 8'h00, 8'h7F, 8'h00, 4'h3},
    {8'h8B, 8'h55, 8'h12, 8'h34, 1'b0, 8'h00, 8'h00, 8'h00, 4'h0}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic void set_nz(input int v, inout logic [3:0] f);
    f[3] = v[7];
    f[2] = (v[7:0] == 8'h00);
  endfunction

  // Reference model written from the requirements.
  function automatic void model(
    input  logic [7:0] op, m, a, x, input logic c,
    output logic rej, mwe, output logic [7:0] mem,
    output logic awe, xwe, output logic [7:0] na, nx,
    output logic [3:0] fwe, fv);
    int mm, sc, r, s, t;
    logic imm;
    rej = (op[1:0] != 2'b11) || op == 8'h8B || op == 8'h93 || op == 8'h9B ||
          op == 8'h9F || op == 8'hBB;
    imm = (op[4:2] == 3'b010);
    mwe = 0; mem = 0; awe = 0; xwe = 0; na = a; nx = x; fwe = 0; fv = 0;
    mm = m; sc = c; r = a;
    if (rej) return;
    case (op[7:5])
      3'd0: begin mm = (m << 1) & 255; sc = m[7]; end
      3'd1: begin mm = ((m << 1) | c) & 255; sc = m[7]; end
      3'd2: begin mm = m >> 1; sc = m[0]; end
      3'd3: begin mm = (m >> 1) | (c << 7); sc = m[0]; end
      3'd4: mm = a & x;
      3'd6: mm = (m + 255) & 255;
      3'd7: mm = (m + 1) & 255;
      default: mm = m;
    endcase
    mwe = !imm && op[7:5] != 3'd5;
    mem = mwe ? mm[7:0] : 8'h00;
    if (imm) begin mm = m; sc = c; end
    case (op[7:5])
      3'd0, 3'd1, 3'd2: begin
        if (imm && op[7:5] != 3'd2) begin r = a & m; fv[1] = r[7]; end
        else if (imm) begin t = a & m; r = t >> 1; fv[1] = t[0]; end
        else begin
          r = (op[7:5] == 0) ? (a | mm) : (op[7:5] == 1) ? (a & mm) : (a ^ mm);
          fv[1] = sc[0];
        end
        awe = 1; fwe = 4'b1110;
      end
      3'd3: begin
        if (imm) begin
          t = a & m; r = (t >> 1) | (c << 7);
          fv[1] = r[6]; fv[0] = r[6] ^ r[5];
        end else begin
          s = a + mm + sc; r = s & 255;
          fv[1] = s > 255; fv[0] = ((a ^ r) & (mm ^ r) & 128) != 0;
        end
        awe = 1; fwe = 4'b1111;
      end
      3'd4: ;
      3'd5: begin r = m; awe = 1; xwe = 1; nx = m; fwe = 4'b1100; end
      3'd6: begin
        t = imm ? (a & x) : a;
        r = (t - mm) & 255; fv[1] = t >= mm; fwe = 4'b1110;
        if (imm) begin xwe = 1; nx = r[7:0]; end
      end
      default: begin
        s = a - mm - (c ? 0 : 1); r = s & 255;
        fv[1] = s >= 0; fv[0] = ((a ^ mm) & (a ^ r) & 128) != 0;
        awe = 1; fwe = 4'b1111;
      end
    endcase
    if (awe) na = r[7:0];
    if (op[7:5] != 3'd4) set_nz(r, fv);
    fv = fv & fwe;
  endfunction

  task automatic apply(input logic [7:0] op, m, a, x, input logic c,
                       input bit use_tab, input logic [7:0] tmem, ta, tx, input logic [3:0] tf);
    logic rej, mwe, awe, xwe;
    logic [7:0] mem, na, nx;
    logic [3:0] fwe, fv;
    string tag;
    model(op, m, a, x, c, rej, mwe, mem, awe, xwe, na, nx, fwe, fv);
    if (use_tab) begin mem = tmem; na = ta; nx = tx; fv = tf; end
    if (op[4:2] == 3'b010) tag = "R10";
    else case (op[7:5])
      3'd3: tag = "R5";
      3'd4: tag = "R8";
      3'd5: tag = "R9";
      3'd6: tag = "R6";
      3'd7: tag = "R7";
      default: tag = "R4";
    endcase
    @(negedge clk);
    op_valid = 1'b1; opcode = op; operand = m; acc_in = a; idx_in = x; carry_in = c;
    @(negedge clk);
    op_valid = 1'b0;
    chk("R1 unsupported", 16'(unsupported), 16'(rej));
    chk("R2 mem_we", 16'(mem_we), 16'(mwe));
    if (mwe) chk({"R2 mem_wdata ", tag}, 16'(mem_wdata), 16'(mem));
    chk("R3 early commit", 16'(commit), 16'h0);
    if (!rej) chk("R11 mode_code", 16'(mode_code), 16'(op[4:2]));
    @(negedge clk);
    chk("R3 mem_we low at commit", 16'(mem_we), 16'h0);
    chk("R3 commit", 16'(commit), 16'(!rej));
    if (!rej) begin
      chk({tag, " acc_we"}, 16'(acc_we), 16'(awe));
      chk({tag, " idx_we"}, 16'(idx_we), 16'(xwe));
      chk({tag, " flags_we"}, 16'(flags_we), 16'(fwe));
      if (awe) chk({tag, " acc_out"}, 16'(acc_out), 16'(na));
      if (xwe) chk({tag, " idx_out"}, 16'(idx_out), 16'(nx));
      chk({tag, " flags"}, 16'(flags_out & fwe), 16'(fv));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 mem_we", 16'(mem_we), 16'h0);
    chk("R12 commit", 16'(commit), 16'h0);
    chk("R12 unsupported", 16'(unsupported), 16'h0);
    chk("R12 acc_we", 16'(acc_we), 16'h0);
    rst = 1'b0;

    for (int i = 0; i < 14; i++) begin
      logic [60:0] e;
      e = TAB[i];
      apply(e[60:53], e[52:45], e[44:37], e[36:29], e[28],
            1'b1, e[27:20], e[19:12], e[11:4], e[3:0]);
    end

    // R1: low bits not 11, and unstable opcodes in other columns
    apply(8'h69, 8'h11, 8'h22, 8'h33, 1'b0, 1'b0, 0, 0, 0, 0);
    apply(8'h9E, 8'h11, 8'h22, 8'h33, 1'b1, 1'b0, 0, 0, 0, 0);
    apply(8'h9F, 8'h11, 8'h22, 8'h33, 1'b1, 1'b0, 0, 0, 0, 0);
    // R5: rotate carry-out differs from input carry
    apply(8'h6F, 8'hFE, 8'h01, 8'h00, 1'b1, 1'b0, 0, 0, 0, 0);
    // R6: A below decremented byte clears C and keeps A
    apply(8'hD7, 8'h80, 8'h10, 8'h00, 1'b1, 1'b0, 0, 0, 0, 0);
    // R4: rotate-left with carry into bit 0
    apply(8'h3F, 8'h7F, 8'hFF, 8'h00, 1'b1, 1'b0, 0, 0, 0, 0);

    for (int i = 0; i < 400; i++) begin
      logic [7:0] op;
      op = 8'($urandom);
      if (i % 8 != 0) op[1:0] = 2'b11;
      apply(op, 8'($urandom), 8'($urandom), 8'($urandom), 1'($urandom),
            1'b0, 0, 0, 0, 0);
    end

    // R12: reset in the middle of an operation suppresses both slots
    @(negedge clk);
    op_valid = 1'b1; opcode = 8'h07; operand = 8'h01;
    @(negedge clk);
    op_valid = 1'b0; rst = 1'b1;
    @(negedge clk);
    chk("R12 mem_we after reset", 16'(mem_we), 16'h0);
    chk("R12 commit after reset", 16'(commit), 16'h0);
    rst = 1'b0;

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule